// File: doc/BRIEF.md
# Reflected Binary-Field Multiplier (64 to 256 bits)

This block multiplies two elements of a binary extension field GF(2^n) and reduces the product by the field polynomial of the selected size. Five sizes are supported: 64, 96, 128, 192 and 256 bits. Coefficients use the reflected ordering common in authenticated-encryption hashing. Both operands arrive on 256-bit buses with the active field in the top n bits. The reduced product leaves on one 256-bit bus in the same layout. Every bit below the active field is zero.

Internally the block forms the full carry-less product of the two fields. It then moves that product left by one place, because multiplying reflected operands leaves the product offset by one. Finally it folds the overflow half back into the field in two passes. A flag reverses the byte order inside every 32-bit word on the way in and again on the way out. This lets software in either word byte order use the block without a separate conversion.

A request is presented with `inValid` for one cycle. Exactly one cycle later the result is registered on `product` and `outValid` pulses. The result stays on `product` until the next request.

Top module: `gfm_mult`

## Requirements
- R1: In every mode, bus bit 255-i carries the coefficient of t^i, and only bits 255 down to 256-n form the field. Mode code 0 selects n=64 with p(t)=t^64+t^4+t^3+t+1, and `product` equals A·K mod p(t).
- R2: Mode code 1 selects n=96 with p(t)=t^96+t^10+t^9+t^6+1.
- R3: Mode code 2 selects n=128 with p(t)=t^128+t^7+t^2+t+1.
- R4: Mode code 3 selects n=192 with p(t)=t^192+t^7+t^2+t+1.
- R5: Mode code 4 selects n=256 with p(t)=t^256+t^10+t^5+t^2+1.
- R6: Operand bits below the active field (bus bits 255-n down to 0) have no effect on the result, and those same bits of `product` are zero.
- R7: `product` and `outValid` are loaded one cycle after `inValid` is high. `outValid` is high for exactly that cycle. With `inValid` low, `product` holds its value regardless of the other inputs.
- R8: With `wordSwap`=1, each 32-bit word of both operands has its bytes reversed before use. Within a word, bits [31:24] swap with [7:0] and bits [23:16] swap with [15:8]. The same reversal is applied to the result.
- R9: An operand with only bus bit 255 set (the field element 1) returns the other operand's field bits unchanged, in every mode.
- R10: Mode codes 5, 6 and 7 produce an all-zero `product`.
- R11: During reset, `outValid` and `product` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Request strobe; operands and mode are sampled in this cycle |
| modeSel | input | 3 | Field size code (0..4), codes 5..7 unmapped |
| wordSwap | input | 1 | Reverse the bytes in each 32-bit word of operands and result |
| opA | input | 256 | First operand, active field in the top n bits |
| opK | input | 256 | Second operand, active field in the top n bits |
| outValid | output | 1 | Pulses high when `product` has been loaded |
| product | output | 256 | Reduced product, top n bits, zero below |

## Verification
Every result is due on the rising edge that follows the cycle in which `inValid` is high, with no further latency in any mode. The bench drives each request just after a falling edge, lets one rising edge register it, and reads `outValid` and `product` at the next falling edge. The output is therefore stable when it is sampled, and the read is the exact cycle the result is due. Hold behaviour is checked by changing the operands and the mode with `inValid` low and reading again one and two falling edges later.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int MAX_W     = 256;
  localparam int NUM_MODES = 5;
  localparam int MODE_BITS = 3;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = MAX_W / WORD_W;

  typedef struct packed {
    logic                 load;
    logic                 swapBytes;
    logic [NUM_MODES-1:0] widthSel;
  } gfmStrobes_t;

  // field size of each mode code
  function automatic int modeWidth(input int idx);
    case (idx)
      0:       return 64;
      1:       return 96;
      2:       return 128;
      3:       return 192;
      default: return 256;
    endcase
  endfunction

  // non-unit taps of the reduction polynomial, ascending (j = 0..2)
  function automatic int modeTap(input int idx, input int j);
    case (idx)
      0:       return (j == 0) ? 1 : (j == 1) ? 3 : 4;
      1:       return (j == 0) ? 6 : (j == 1) ? 9 : 10;
      4:       return (j == 0) ? 2 : (j == 1) ? 5 : 10;
      default: return (j == 0) ? 1 : (j == 1) ? 2 : 7;
    endcase
  endfunction

  // ones in the top 'width' bits of the bus
  function automatic logic [MAX_W-1:0] topMask(input int width);
    return ~({MAX_W{1'b1}} >> width);
  endfunction

  function automatic logic [MAX_W-1:0] swapWordBytes(input logic [MAX_W-1:0] v);
    logic [MAX_W-1:0] r;
    for (int w = 0; w < NUM_WORDS; w++) begin
      for (int b = 0; b < 4; b++) begin
        r[w*WORD_W + b*8 +: 8] = v[w*WORD_W + (3-b)*8 +: 8];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
  import gfm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [MODE_BITS-1:0] modeSel,
  input  logic                 wordSwap,
  output gfmStrobes_t          strobes,
  output logic                 outValid
);

  always_comb begin
    strobes.load      = inValid;
    strobes.swapBytes = wordSwap;
    for (int m = 0; m < NUM_MODES; m++) begin
      strobes.widthSel[m] = (modeSel == MODE_BITS'(m));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7: the done pulse trails each request by exactly one cycle
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid) |-> outValid)
    else $error("outValid missing after request");

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid)
    else $error("outValid without request");

endmodule

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int W = 256
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  localparam int PW = 2*W - 1;

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) p = p ^ ({{(PW-W){1'b0}}, a} << i);
    end
  end
endmodule

// File: rtl/gfm_reduce.sv
// Reduction of a realigned reflected product (coefficient k at bit PW-1-k).
module gfm_reduce #(
  parameter int MW = 256,
  parameter int N  = 128,
  parameter int E1 = 1,
  parameter int E2 = 2,
  parameter int E3 = 7
) (
  input  logic [2*MW-1:0] prodIn,
  output logic [MW-1:0]   resOut
);
  localparam int PW = 2*MW;
  localparam logic [PW-1:0] ONES    = {PW{1'b1}};
  localparam logic [PW-1:0] IN_M    = ~(ONES >> (2*N));
  localparam logic [PW-1:0] LOW_M   = ~(ONES >> N);
  localparam logic [PW-1:0] SPILL_M = ~(ONES >> (N + E3)) & ~LOW_M;

  function automatic logic [PW-1:0] foldDown(input logic [PW-1:0] h);
    logic [PW-1:0] s;
    s = h << N;
    return s ^ (s >> E1) ^ (s >> E2) ^ (s >> E3);
  endfunction

  logic [PW-1:0] inField;
  logic [PW-1:0] passOne;
  logic [PW-1:0] passTwo;

  always_comb begin
    inField = prodIn & IN_M;
    passOne = (inField & LOW_M) ^ foldDown(inField & ~LOW_M);
    passTwo = (passOne & LOW_M) ^ foldDown(passOne & ~LOW_M);
    resOut  = passTwo[PW-1 -: MW];
  end

  // R1..R5: first fold leaves at most E3 spill coefficients, so a second fold finishes
  always_comb begin
    a_r1_spill_bounded: assert ((passOne & ~LOW_M & ~SPILL_M) == '0)
      else $error("reduction spill exceeds bound");
  end
endmodule

// File: rtl/gfm_datapath.sv
module gfm_datapath
  import gfm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  gfmStrobes_t      strobes,
  input  logic [MAX_W-1:0] opA,
  input  logic [MAX_W-1:0] opK,
  output logic [MAX_W-1:0] product
);
  localparam int PW = 2*MAX_W;

  logic [MAX_W-1:0] selMask;
  logic [MAX_W-1:0] aIn, kIn, aField, kField;
  logic [PW-2:0]    rawProd;
  logic [PW-1:0]    alignedProd;
  logic [MAX_W-1:0] modeRes [NUM_MODES];
  logic [MAX_W-1:0] merged, outBus;

  always_comb begin
    selMask = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (strobes.widthSel[m]) selMask = selMask | topMask(modeWidth(m));
    end
    aIn    = strobes.swapBytes ? swapWordBytes(opA) : opA;
    kIn    = strobes.swapBytes ? swapWordBytes(opK) : opK;
    aField = aIn & selMask;
    kField = kIn & selMask;
  end

  gfm_clmul #(.W(MAX_W)) u_clmul (
    .a (aField),
    .b (kField),
    .p (rawProd)
  );

  // reflected operands give the product one place low; move it back
  assign alignedProd = {rawProd, 1'b0};

  generate
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      gfm_reduce #(
        .MW (MAX_W),
        .N  (modeWidth(m)),
        .E1 (modeTap(m, 0)),
        .E2 (modeTap(m, 1)),
        .E3 (modeTap(m, 2))
      ) u_reduce (
        .prodIn (alignedProd),
        .resOut (modeRes[m])
      );
    end
  endgenerate

  always_comb begin
    merged = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      merged = merged | (modeRes[m] & {MAX_W{strobes.widthSel[m]}});
    end
    outBus = strobes.swapBytes ? swapWordBytes(merged) : merged;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             product <= '0;
    else if (strobes.load) product <= outBus;
  end

  // R6: nothing appears below the selected field
  a_r6_below_field_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load) |-> ((product & ~$past(selMask)) == '0))
    else $error("bits below field set");

  // R7: product holds without a request
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.load) |-> $stable(product))
    else $error("product changed without request");

  // R10: unmapped mode codes produce zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.load) && ($past(strobes.widthSel) == '0)) |-> (product == '0))
    else $error("unmapped mode gave nonzero product");
endmodule

// File: rtl/gfm_mult.sv
module gfm_mult
  import gfm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [MODE_BITS-1:0] modeSel,
  input  logic                 wordSwap,
  input  logic [MAX_W-1:0]     opA,
  input  logic [MAX_W-1:0]     opK,
  output logic                 outValid,
  output logic [MAX_W-1:0]     product
);
  gfmStrobes_t strobes;

  gfm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeSel  (modeSel),
    .wordSwap (wordSwap),
    .strobes  (strobes),
    .outValid (outValid)
  );

  gfm_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opK     (opK),
    .product (product)
  );
endmodule

// File: tb/gfm_mult_test.sv
`timescale 1ns/1ps
module gfm_mult_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [2:0]   modeSel = '0;
  logic         wordSwap = 1'b0;
  logic [255:0] opA = '0;
  logic [255:0] opK = '0;
  logic         outValid;
  logic [255:0] product;

  int checks = 0;
  int errors = 0;

  gfm_mult uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .wordSwap(wordSwap), .opA(opA), .opK(opK), .outValid(outValid), .product(product)
  );

  always #5 clk = ~clk;

  function automatic int widthOf(input int mode);
    case (mode)
      0: return 64;  1: return 96;  2: return 128;  3: return 192;
      default: return 256;
    endcase
  endfunction

  function automatic string reqOf(input int mode);
    case (mode)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [255:0] maskOf(input int mode);
    logic [255:0] m;
    m = '0;
    for (int i = 0; i < widthOf(mode); i++) m[255-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [255:0] bsw(input logic [255:0] v);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) begin
      r[w*32+31 -: 8] = v[w*32+7  -: 8];
      r[w*32+23 -: 8] = v[w*32+15 -: 8];
      r[w*32+15 -: 8] = v[w*32+23 -: 8];
      r[w*32+7  -: 8] = v[w*32+31 -: 8];
    end
    return r;
  endfunction

  // bit-serial shift-and-add in natural coefficient order
  function automatic logic [255:0] refMul(input logic [255:0] a, input logic [255:0] k,
                                          input int mode);
    int n;
    logic [256:0] poly, acc, an, kn;
    logic [255:0] res;
    n = widthOf(mode);
    poly = '0; poly[n] = 1'b1; poly[0] = 1'b1;
    case (mode)
      0: begin poly[1] = 1'b1; poly[3] = 1'b1; poly[4] = 1'b1; end
      1: begin poly[6] = 1'b1; poly[9] = 1'b1; poly[10] = 1'b1; end
      4: begin poly[2] = 1'b1; poly[5] = 1'b1; poly[10] = 1'b1; end
      default: begin poly[1] = 1'b1; poly[2] = 1'b1; poly[7] = 1'b1; end
    endcase
    an = '0; kn = '0;
    for (int i = 0; i < n; i++) begin
      an[i] = a[255-i];
      kn[i] = k[255-i];
    end
    acc = '0;
    for (int i = n - 1; i >= 0; i--) begin
      acc = acc << 1;
      if (acc[n]) acc = acc ^ poly;
      if (kn[i]) acc = acc ^ an;
    end
    res = '0;
    for (int i = 0; i < n; i++) res[255-i] = acc[i];
    return res;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic checkBit(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic checkBus(input logic [255:0] got, input logic [255:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // called right after a falling edge; returns after the next one
  task automatic runOp(input logic [255:0] a, input logic [255:0] k, input int mode,
                       input bit sw, input logic [255:0] exp, input string what);
    opA = a; opK = k; modeSel = 3'(mode); wordSwap = sw; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit(outValid, 1'b1, {what, " R7 outValid"});
    checkBus(product, exp, what);
  endtask

  function automatic logic [255:0] expOf(input logic [255:0] a, input logic [255:0] k,
                                         input int mode, input bit sw);
    if (mode > 4) return '0;
    if (sw) return bsw(refMul(bsw(a), bsw(k), mode));
    return refMul(a, k, mode);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] a, k, held;
    // R11: reset state
    repeat (3) @(negedge clk);
    checkBit(outValid, 1'b0, "R11 outValid in reset");
    checkBus(product, '0, "R11 product in reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1..R5 with R8: random sweep in every mode, both byte orders
    for (int mode = 0; mode < 5; mode++) begin
      for (int sw = 0; sw < 2; sw++) begin
        for (int t = 0; t < 12; t++) begin
          a = rnd256(); k = rnd256();
          runOp(a, k, mode, sw[0], expOf(a, k, mode, sw[0]),
                {reqOf(mode), sw ? " R8 swapped" : " R6 random"});
        end
      end
      // reduction stress: all-ones operands
      runOp('1, '1, mode, 1'b0, expOf('1, '1, mode, 1'b0), {reqOf(mode), " all ones"});
    end

    // R9: multiply by one in every mode; junk below field must be dropped (R6)
    for (int mode = 0; mode < 5; mode++) begin
      logic [255:0] one;
      one = '0; one[255] = 1'b1;
      a = rnd256();
      runOp(a, one, mode, 1'b0, a & maskOf(mode), {reqOf(mode), " R9 A times one"});
      runOp(one | ~maskOf(mode), a, mode, 1'b0, a & maskOf(mode),
            {reqOf(mode), " R9 R6 one with junk times K"});
    end

    // R6: junk below the field does not change the result
    for (int mode = 0; mode < 4; mode++) begin
      a = rnd256() & maskOf(mode);
      k = rnd256() & maskOf(mode);
      runOp(a | (rnd256() & ~maskOf(mode)), k | (rnd256() & ~maskOf(mode)), mode, 1'b0,
            refMul(a, k, mode), {reqOf(mode), " R6 junk ignored"});
    end

    // R10: unmapped mode codes
    for (int mode = 5; mode < 8; mode++) begin
      runOp(rnd256(), rnd256(), mode, 1'b0, '0, "R10 unmapped mode");
    end

    // R7: hold without a request
    a = rnd256(); k = rnd256();
    runOp(a, k, 2, 1'b0, expOf(a, k, 2, 1'b0), "R3 before hold");
    held = expOf(a, k, 2, 1'b0);
    opA = rnd256(); opK = rnd256(); modeSel = 3'd4; wordSwap = 1'b1;
    @(negedge clk);
    checkBit(outValid, 1'b0, "R7 outValid low after pulse");
    checkBus(product, held, "R7 product held");
    @(negedge clk);
    checkBus(product, held, "R7 product still held");

    // R7: back-to-back requests each land one cycle later
    a = rnd256(); k = rnd256();
    runOp(a, k, 0, 1'b0, expOf(a, k, 0, 1'b0), "R1 R7 back to back first");
    runOp(k, a, 3, 1'b1, expOf(k, a, 3, 1'b1), "R4 R7 back to back second");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule